// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Programming

This block sits between a serial-bus front-end and the write port of a nonvolatile memory array. While a write transaction is open, the front-end hands over data bytes one strobe at a time. With the first byte it also supplies the starting array address. The block keeps the bytes in a small local buffer and answers every byte with a one-cycle accept or refuse pulse.

A mode input, sampled with the first byte, selects the page size. A small page holds two bytes. A large page holds eight bytes, configurable by parameter.

- **Small page overflow.** A third byte is refused. The transaction is then dead until the next STOP.
- **Large page overflow.** The buffer wraps and overwrites the oldest slots. The target address advances only in its low offset bits, so it never leaves the page.

When STOP arrives with at least one byte held, a self-timed programming sequence starts. It spends one time unit (a parameterised number of clock cycles) per buffered byte. At the end of each unit it issues one array write. A busy flag stays raised for the whole sequence, so the front-end refuses new traffic during programming.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, busy, arr_we, byte_ack and byte_nack are all low.
- R2: Each byte_stb produces exactly one of byte_ack or byte_nack, as a single-cycle pulse in the cycle after the strobe. The mode input is captured with the first byte of a transaction.
- R3: In small mode (mode_large=0), the first two bytes are accepted. The third byte and every later byte of that transaction are refused. The STOP that follows programs nothing and leaves busy low.
- R4: In large mode (mode_large=1), bytes beyond eight wrap. Byte k lands in slot k mod 8, the count saturates at eight, and each of the eight slots is written exactly once, carrying the last byte that landed in it.
- R5: Every array write address keeps start_addr's bits above the low three unchanged. Its low three bits equal start_addr[2:0] plus the slot number, modulo 8. This holds in both modes.
- R6: A STOP after exactly one accepted byte produces a single write of that byte to start_addr.
- R7: arr_we is never raised while bytes are being collected or before STOP. Writes occur only as part of a programming sequence.
- R8: The STOP is sampled on a clock edge E, and N bytes are held, with TICK_CYCLES cycles per unit.
  - The j-th write (j=1..N) pulses arr_we for one cycle, registered at edge E+j·TICK_CYCLES.
  - busy is high from edge E through the cycle after the last write: N·TICK_CYCLES+1 cycles in total.
- R9: While busy, every byte strobe is refused and STOP is ignored. The programming in progress completes unchanged.
- R10: A STOP with no bytes held, or a STOP after an aborted transaction, returns the block to idle. busy never rises and no write is issued.
- R11: Programming writes the slots in ascending order, from slot 0 to slot N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_large | input | 1 | Page size select: 1 = eight bytes, 0 = two bytes (sampled with the first byte) |
| byte_stb | input | 1 | Data byte valid strobe |
| byte_data | input | DATA_W | Data byte |
| start_addr | input | ADDR_W | Starting array address (sampled with the first byte) |
| stop_pulse | input | 1 | End of transaction |
| byte_ack | output | 1 | Byte accepted pulse |
| byte_nack | output | 1 | Byte refused pulse |
| busy | output | 1 | Programming in progress |
| arr_we | output | 1 | Array write enable pulse |
| arr_addr | output | ADDR_W | Array write address |
| arr_data | output | DATA_W | Array write data |

## Verification
Different internal faults show up at different points on the ports:
- **Slot pointer or wrap offset.** A wrong value shows only once programming runs, as a write to the wrong address or with stale data. The write list is compared in full against a model of the transaction.
- **Byte count.** A wrong count appears as too many or too few arr_we pulses, and as a busy window of the wrong length, visible within one time unit of the error.
- **Abort or mode bookkeeping.** A fault here shows immediately in the accept/refuse pulse of the third byte, and again at STOP, when busy rises where it should not.
- **Tick counter.** A fault shifts each write pulse off its exact cycle; every pulse is timed against the STOP edge.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic [1:0] {
        PW_FILL  = 2'd0,
        PW_ABORT = 2'd1,
        PW_PROG  = 2'd2
    } pw_state_e;
endpackage

// File: rtl/pwb_slot_store.sv
module pwb_slot_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DEPTH-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_idx];

    AST_SLOTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (mem_q == $past(mem_q))); // R9
endmodule

// File: rtl/pwb_unit_timer.sv
module pwb_unit_timer #(
    parameter int TICK_CYCLES = 1000,
    localparam int TICK_W = $clog2(TICK_CYCLES) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic unit_done
);
    logic [TICK_W-1:0] tick_d, tick_q;

    always_comb begin
        unit_done = run && (tick_q == TICK_W'(TICK_CYCLES - 1));
        if (!run || unit_done) begin
            tick_d = '0;
        end else begin
            tick_d = tick_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_d;
        end
    end

    AST_TICK_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !unit_done) |=> (tick_q == TICK_W'($past(tick_q) + 1'b1))); // R8
    AST_TICK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (tick_q == '0)); // R8
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer
    import pwb_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int DATA_W      = 8,
    parameter int BIG_PAGE    = 8,
    parameter int SMALL_PAGE  = 2,
    parameter int TICK_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_large,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_data,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              stop_pulse,
    output logic              byte_ack,
    output logic              byte_nack,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_data
);
    localparam int OFS_W = $clog2(BIG_PAGE);
    localparam int CNT_W = OFS_W + 1;
    localparam logic [CNT_W-1:0] BIG_CNT   = CNT_W'(BIG_PAGE);
    localparam logic [CNT_W-1:0] SMALL_CNT = CNT_W'(SMALL_PAGE);

    typedef struct packed {
        pw_state_e         st;
        logic              big;
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  cnt;
        logic [OFS_W-1:0]  wofs;
        logic [CNT_W-1:0]  pidx;
        logic              ack;
        logic              nack;
        logic              we;
        logic [ADDR_W-1:0] waddr;
        logic [DATA_W-1:0] wdata;
    } ctl_t;

    ctl_t c_d, c_q;

    logic              busy_w;
    logic              buf_we;
    logic [OFS_W-1:0]  buf_widx;
    logic [DATA_W-1:0] buf_rdata;
    logic              tmr_run;
    logic              unit_done;
    logic              big_now;
    logic [OFS_W-1:0]  slot_now;

    pwb_slot_store #(
        .DATA_W (DATA_W),
        .DEPTH  (BIG_PAGE)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_we),
        .wr_idx  (buf_widx),
        .wr_data (byte_data),
        .rd_idx  (c_q.pidx[OFS_W-1:0]),
        .rd_data (buf_rdata)
    );

    pwb_unit_timer #(
        .TICK_CYCLES (TICK_CYCLES)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (tmr_run),
        .unit_done (unit_done)
    );

    always_comb begin
        c_d      = c_q;
        c_d.ack  = 1'b0;
        c_d.nack = 1'b0;
        c_d.we   = 1'b0;
        busy_w   = (c_q.st == PW_PROG) || c_q.we;
        buf_we   = 1'b0;
        buf_widx = '0;
        tmr_run  = 1'b0;
        big_now  = (c_q.cnt == '0) ? mode_large : c_q.big;
        slot_now = (c_q.cnt == '0) ? '0 : c_q.wofs;

        unique case (c_q.st)
            PW_FILL: begin
                if (byte_stb) begin
                    if (busy_w) begin
                        c_d.nack = 1'b1;
                    end else if (!big_now && (c_q.cnt == SMALL_CNT)) begin
                        c_d.nack = 1'b1;
                        c_d.st   = PW_ABORT;
                        c_d.cnt  = '0;
                    end else begin
                        c_d.ack  = 1'b1;
                        buf_we   = 1'b1;
                        buf_widx = slot_now;
                        c_d.wofs = slot_now + 1'b1;
                        if (c_q.cnt == '0) begin
                            c_d.base = start_addr;
                            c_d.big  = mode_large;
                        end
                        if (c_q.cnt != BIG_CNT) begin
                            c_d.cnt = c_q.cnt + 1'b1;
                        end
                    end
                end else if (stop_pulse && !busy_w && (c_q.cnt != '0)) begin
                    c_d.st   = PW_PROG;
                    c_d.pidx = '0;
                end
            end
            PW_ABORT: begin
                if (byte_stb) begin
                    c_d.nack = 1'b1;
                end else if (stop_pulse) begin
                    c_d.st  = PW_FILL;
                    c_d.cnt = '0;
                end
            end
            PW_PROG: begin
                tmr_run = 1'b1;
                if (byte_stb) begin
                    c_d.nack = 1'b1;
                end
                if (unit_done) begin
                    c_d.we    = 1'b1;
                    c_d.wdata = buf_rdata;
                    c_d.waddr = {c_q.base[ADDR_W-1:OFS_W],
                                 c_q.base[OFS_W-1:0] + c_q.pidx[OFS_W-1:0]};
                    c_d.pidx  = c_q.pidx + 1'b1;
                    if (c_q.pidx == c_q.cnt - 1'b1) begin
                        c_d.st  = PW_FILL;
                        c_d.cnt = '0;
                    end
                end
            end
            default: begin
                c_d.st  = PW_FILL;
                c_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= PW_FILL;
        end else begin
            c_q <= c_d;
        end
    end

    assign byte_ack  = c_q.ack;
    assign byte_nack = c_q.nack;
    assign busy      = busy_w;
    assign arr_we    = c_q.we;
    assign arr_addr  = c_q.waddr;
    assign arr_data  = c_q.wdata;

    AST_ACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_ack && byte_nack)); // R2
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_stb |=> !(byte_ack || byte_nack)); // R2
    AST_SMALL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !c_q.big |-> (c_q.cnt <= SMALL_CNT)); // R3
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == PW_ABORT) |-> (!busy && !arr_we)); // R3
    AST_COUNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.cnt <= BIG_CNT); // R4
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (arr_addr[ADDR_W-1:OFS_W] == c_q.base[ADDR_W-1:OFS_W])); // R5
    AST_WRITE_FROM_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> ($past(c_q.st) == PW_PROG)); // R7
    AST_BUSY_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.st == PW_FILL) && stop_pulse && !byte_stb && !busy && (c_q.cnt != '0))
        |=> busy); // R8
    AST_EMPTY_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.st != PW_PROG) && !busy && !byte_stb && (c_q.cnt == '0)) |=> !busy); // R10
endmodule

// File: tb/page_write_buffer_tb.sv
module page_write_buffer_tb_top;
    localparam int TICK = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_large = 1'b0;
    logic       byte_stb = 1'b0;
    logic [7:0] byte_data = '0;
    logic [8:0] start_addr = '0;
    logic       stop_pulse = 1'b0;
    logic       byte_ack, byte_nack, busy, arr_we;
    logic [8:0] arr_addr;
    logic [7:0] arr_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    page_write_buffer #(
        .ADDR_W (9), .DATA_W (8), .BIG_PAGE (8), .SMALL_PAGE (2), .TICK_CYCLES (TICK)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .mode_large (mode_large), .byte_stb (byte_stb),
        .byte_data (byte_data), .start_addr (start_addr), .stop_pulse (stop_pulse),
        .byte_ack (byte_ack), .byte_nack (byte_nack), .busy (busy), .arr_we (arr_we),
        .arr_addr (arr_addr), .arr_data (arr_data)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_writes(input bit big, input int n);
        if (!big && n > 2) return 0;
        return (n > 8) ? 8 : n;
    endfunction

    function automatic int last_idx(input int s, input int n);
        return s + 8 * ((n - 1 - s) / 8);
    endfunction

    function automatic logic [8:0] slot_addr(input logic [8:0] sa, input int s);
        logic [2:0] lo;
        lo = sa[2:0] + 3'(s);
        return {sa[8:3], lo};
    endfunction

    task automatic run_seq(input bit big, input logic [8:0] sa, input int n, input bit inject);
        logic [7:0] dat[16];
        int m, bcnt, widx, limit;
        bit exp_ok;
        for (int k = 0; k < n; k++) dat[k] = 8'($urandom);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            byte_stb = 1'b1; byte_data = dat[k];
            start_addr = (k == 0) ? sa : ~sa;
            mode_large = (k == 0) ? big : ~big;
            @(negedge clk);
            byte_stb = 1'b0;
            exp_ok = big || (k < 2);
            chk(big ? "R2" : "R3", "ack", int'(byte_ack), int'(exp_ok));
            chk("R2", "nack", int'(byte_nack), int'(!exp_ok));
            chk("R7", "no write while collecting", int'(arr_we), 0);
        end
        m = exp_writes(big, n);
        @(negedge clk);
        stop_pulse = 1'b1;
        @(negedge clk);
        stop_pulse = 1'b0;
        bcnt = 0; widx = 0;
        limit = m * TICK + 8;
        for (int c = 1; c <= limit; c++) begin
            if (busy) bcnt++;
            if (inject && m > 0 && c == 2) begin
                byte_stb = 1'b1; byte_data = 8'hA5; stop_pulse = 1'b1;
            end
            if (inject && m > 0 && c == 3) begin
                byte_stb = 1'b0; stop_pulse = 1'b0;
                chk("R9", "nack while busy", int'(byte_nack), 1);
                chk("R9", "no ack while busy", int'(byte_ack), 0);
            end
            if (arr_we) begin
                if (widx < m) begin
                    chk("R8", "write cycle", c, (widx + 1) * TICK + 1);
                    chk("R5", "write address", int'(arr_addr), int'(slot_addr(sa, widx)));
                    chk("R4", "write data", int'(arr_data), int'(dat[last_idx(widx, n)]));
                end
                widx++;
            end
            @(negedge clk);
        end
        chk((m == 0) ? "R10" : "R8", "busy cycles", bcnt, (m == 0) ? 0 : m * TICK + 1);
        chk((n == 1) ? "R6" : "R11", "write count", widx, m);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        chk("R1", "busy after reset", int'(busy), 0);
        chk("R1", "we after reset", int'(arr_we), 0);
        chk("R1", "ack after reset", int'(byte_ack | byte_nack), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy idle", int'(busy), 0);
        run_seq(1'b0, 9'h0C3, 1, 1'b0);   // R6
        run_seq(1'b1, 9'h1F7, 1, 1'b1);   // R6 large
        run_seq(1'b0, 9'h047, 2, 1'b1);   // R5 wrap in small mode
        run_seq(1'b0, 9'h010, 3, 1'b0);   // R3
        run_seq(1'b0, 9'h011, 6, 1'b0);   // R3
        run_seq(1'b1, 9'h020, 0, 1'b0);   // R10
        run_seq(1'b0, 9'h020, 0, 1'b0);   // R10
        run_seq(1'b1, 9'h135, 8, 1'b1);   // R4 R11
        run_seq(1'b1, 9'h0A2, 11, 1'b0);  // R4
        run_seq(1'b1, 9'h0FF, 16, 1'b1);  // R4
        for (int i = 0; i < 30; i++) begin
            run_seq(1'($urandom), 9'($urandom), int'($urandom_range(0, 12)), 1'($urandom));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule